// File: doc/BRIEF.md
# Write Buffer Hit-Ratio Monitor

This block observes the per-DWORD outcome stream of a write-combining buffer. Each DWORD that a requester writes into the buffer produces one event. The event says whether the data landed on a location already held in the buffer, which is a hit, or needed a fresh entry, which is a miss. The event also names the requester that issued the write: the CPU, the PCI bridge or the DMA engine. Every DWORD is a separate event, whether it was full or partial and whether it came from a single transfer or from a burst of two to four DWORDs.

The block holds two monitor channels that work independently. Each channel is given one requester to watch and an enable. It keeps a hit count and a total count, and software reads both to work out the hit/miss ratio (misses = total - hits). Both counters saturate, and each has a sticky flag that records that a count was lost. Software configures, clears and reads the channels through a small register port. The read port is combinational.

Top module: `wbuf_hit_monitor`

## Requirements
- R1: After synchronous reset, every register reads zero: enable is off, the source field is 0, both counters are 0 and both overflow flags are 0.
- R2: Each channel has its own control register. Bit 0 is enable and bits 2:1 select the source: 0 = CPU, 1 = PCI bridge, 2 = DMA engine. Code 3 matches no event. A control read returns bits 2:0 as written, with 0 in every other bit. Writing one channel has no effect on the other.
- R3: When a channel is enabled, each cycle with evt_valid high and evt_src equal to its selected source adds exactly one to its total count. The same event adds one to its hit count when evt_hit is 1.
- R4: Neither counter passes all-ones. An event that would increment a counter already at all-ones leaves the counter unchanged and sets that counter's overflow flag. The flag stays set until a clear. The status register holds the hit flag in bit 0 and the total flag in bit 1.
- R5: A control write with bit 3 set zeros both counters and both flags of that channel at that clock edge. Any event in the same cycle is discarded for that channel. Bit 3 always reads back as 0.
- R6: A disabled channel does not change its counters. An event from a source the channel has not selected does not change its counters.
- R7: Register address = channel * 4 + field, with field 0 = control, 1 = hit count, 2 = total count, 3 = status. Counter values read zero-extended to 32 bits, and reg_rdata follows reg_addr in the same cycle.
- R8: A control write changes the enable and the source starting with the events of the next cycle. An event in the cycle of the write is judged against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register address, channel * 4 + field |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_valid | input | 1 | One DWORD write event is present |
| evt_hit | input | 1 | The DWORD hit an existing buffer entry |
| evt_src | input | 2 | Requester of the DWORD: 0 CPU, 1 PCI bridge, 2 DMA |

## Verification
The bench builds the block with NUM_CH = 2 and CNT_W = 4. With 4-bit counters, saturation and the sticky overflow flags are reached after sixteen events, both in directed bursts and over and over in the random phase. At the default width of 32 bits these cases could not be reached in a run of any reasonable length. The two-channel build lets one event stream hit one channel while the other ignores it. It also shows that a clear or a reconfiguration of one channel leaves the other channel's counts as they were.

// File: rtl/wbhm_pkg.sv
package wbhm_pkg;

    localparam int REG_W = 32;

    // control register bit positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SRC_LSB = 1;
    localparam int CTRL_CLR_BIT = 3;

    // status register bit positions
    localparam int STAT_HOVF_BIT = 0;
    localparam int STAT_TOVF_BIT = 1;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'd0,
        SRC_PCI  = 2'd1,
        SRC_DMA  = 2'd2,
        SRC_NONE = 2'd3
    } wb_src_e;

    typedef enum logic [1:0] {
        FLD_CTRL   = 2'd0,
        FLD_HIT    = 2'd1,
        FLD_TOTAL  = 2'd2,
        FLD_STATUS = 2'd3
    } reg_field_e;

    typedef struct packed {
        logic    valid;
        logic    hit;
        wb_src_e src;
    } wb_event_t;

    typedef struct packed {
        logic    en;
        wb_src_e src;
    } chan_cfg_t;

    // true when the event belongs to this channel's selected requester
    function automatic logic src_match(chan_cfg_t cfg, wb_event_t ev);
        return cfg.en && ev.valid && (cfg.src != SRC_NONE) && (ev.src == cfg.src);
    endfunction

    function automatic chan_cfg_t decode_ctrl(logic [REG_W-1:0] wd);
        chan_cfg_t c;
        c.en  = wd[CTRL_EN_BIT];
        c.src = wb_src_e'(wd[CTRL_SRC_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] encode_ctrl(chan_cfg_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[CTRL_EN_BIT]        = c.en;
        r[CTRL_SRC_LSB +: 2]  = c.src;
        return r;
    endfunction

endpackage

// File: rtl/wbhm_sat_counter.sv
module wbhm_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (inc) begin
            if (count == MAXV) begin
                ovf <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wbhm_channel.sv
module wbhm_channel
    import wbhm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  wb_event_t            ev,
    output chan_cfg_t            cfg,
    output logic                 clr,
    output logic [CNT_W-1:0]     hit_cnt,
    output logic [CNT_W-1:0]     tot_cnt,
    output logic                 hit_ovf,
    output logic                 tot_ovf
);
    logic take;
    logic inc_tot;
    logic inc_hit;

    assign clr     = cfg_we && cfg_wdata[CTRL_CLR_BIT];
    assign take    = src_match(cfg, ev);
    assign inc_tot = take && !clr;
    assign inc_hit = take && !clr && ev.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.en  <= 1'b0;
            cfg.src <= SRC_CPU;
        end else if (cfg_we) begin
            cfg <= decode_ctrl(cfg_wdata);
        end
    end

    wbhm_sat_counter #(.W(CNT_W)) u_hit (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .inc   (inc_hit),
        .count (hit_cnt),
        .ovf   (hit_ovf)
    );

    wbhm_sat_counter #(.W(CNT_W)) u_tot (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .inc   (inc_tot),
        .count (tot_cnt),
        .ovf   (tot_ovf)
    );
endmodule

// File: rtl/wbhm_readmux.sv
module wbhm_readmux
    import wbhm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int CH_W   = 1
) (
    input  logic [CH_W+1:0]      addr,
    input  chan_cfg_t            cfg     [NUM_CH],
    input  logic [CNT_W-1:0]     hit_cnt [NUM_CH],
    input  logic [CNT_W-1:0]     tot_cnt [NUM_CH],
    input  logic [NUM_CH-1:0]    hit_ovf,
    input  logic [NUM_CH-1:0]    tot_ovf,
    output logic [REG_W-1:0]     rdata
);
    logic [CH_W-1:0] ch;
    reg_field_e      fld;

    assign ch  = addr[CH_W+1:2];
    assign fld = reg_field_e'(addr[1:0]);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch == CH_W'(i)) begin
                unique case (fld)
                    FLD_CTRL:   rdata = encode_ctrl(cfg[i]);
                    FLD_HIT:    rdata = REG_W'(hit_cnt[i]);
                    FLD_TOTAL:  rdata = REG_W'(tot_cnt[i]);
                    FLD_STATUS: begin
                        rdata[STAT_HOVF_BIT] = hit_ovf[i];
                        rdata[STAT_TOVF_BIT] = tot_ovf[i];
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/wbuf_hit_monitor.sv
module wbuf_hit_monitor
    import wbhm_pkg::*;
#(
    parameter  int NUM_CH = 2,
    parameter  int CNT_W  = 32,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              evt_valid,
    input  logic              evt_hit,
    input  logic [1:0]        evt_src
);
    wb_event_t          ev;
    chan_cfg_t          ch_cfg  [NUM_CH];
    logic [CNT_W-1:0]   ch_hit  [NUM_CH];
    logic [CNT_W-1:0]   ch_tot  [NUM_CH];
    logic [NUM_CH-1:0]  ch_hovf;
    logic [NUM_CH-1:0]  ch_tovf;
    logic [NUM_CH-1:0]  ch_clr;
    logic [NUM_CH-1:0]  ch_en;
    logic [NUM_CH-1:0]  ch_we;

    assign ev.valid = evt_valid;
    assign ev.hit   = evt_hit;
    assign ev.src   = wb_src_e'(evt_src);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_we[c] = reg_we
                       && (reg_addr[ADDR_W-1:2] == CH_W'(c))
                       && (reg_addr[1:0] == FLD_CTRL);
        assign ch_en[c] = ch_cfg[c].en;

        wbhm_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (ch_we[c]),
            .cfg_wdata (reg_wdata),
            .ev        (ev),
            .cfg       (ch_cfg[c]),
            .clr       (ch_clr[c]),
            .hit_cnt   (ch_hit[c]),
            .tot_cnt   (ch_tot[c]),
            .hit_ovf   (ch_hovf[c]),
            .tot_ovf   (ch_tovf[c])
        );
    end

    wbhm_readmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_rd (
        .addr    (reg_addr),
        .cfg     (ch_cfg),
        .hit_cnt (ch_hit),
        .tot_cnt (ch_tot),
        .hit_ovf (ch_hovf),
        .tot_ovf (ch_tovf),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/wbhm_checker.sv
module wbhm_checker #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_clr,
    input logic [CNT_W-1:0]  ch_hit [NUM_CH],
    input logic [CNT_W-1:0]  ch_tot [NUM_CH],
    input logic [NUM_CH-1:0] ch_hovf,
    input logic [NUM_CH-1:0] ch_tovf
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
            ch_clr[c] |=> (ch_hit[c] == '0) && (ch_tot[c] == '0) && !ch_hovf[c] && !ch_tovf[c]); // R5
        AST_HIT_LE_TOTAL: assert property (@(posedge clk) disable iff (rst)
            ch_hit[c] <= ch_tot[c]); // R3
        AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (rst)
            !ch_clr[c] |=> (ch_tot[c] == $past(ch_tot[c])) || (ch_tot[c] == $past(ch_tot[c]) + 1'b1)); // R3
        AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
            (!ch_en[c] && !ch_clr[c]) |=> $stable(ch_hit[c]) && $stable(ch_tot[c])); // R6
        AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
            ((ch_tot[c] == MAXV) && !ch_clr[c]) |=> (ch_tot[c] == MAXV)); // R4
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            ch_tovf[c] |-> (ch_tot[c] == MAXV)); // R4
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ch_hovf[c] && !ch_clr[c]) |=> ch_hovf[c]); // R4
    end
endmodule

bind wbuf_hit_monitor wbhm_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ch_en   (ch_en),
    .ch_clr  (ch_clr),
    .ch_hit  (ch_hit),
    .ch_tot  (ch_tot),
    .ch_hovf (ch_hovf),
    .ch_tovf (ch_tovf)
);

// File: tb/wbuf_hit_monitor_test.sv
module wbuf_hit_monitor_test;
    localparam int NCH  = 2;
    localparam int CW   = 4;
    localparam int MAXV = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_valid = 1'b0;
    logic        evt_hit = 1'b0;
    logic [1:0]  evt_src = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    bit       m_en   [NCH];
    bit [1:0] m_sel  [NCH];
    int       m_hit  [NCH];
    int       m_tot  [NCH];
    bit       m_hovf [NCH];
    bit       m_tovf [NCH];

    wbuf_hit_monitor #(.NUM_CH(NCH), .CNT_W(CW)) uut (
        .clk (clk), .rst (rst), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .evt_valid (evt_valid), .evt_hit (evt_hit), .evt_src (evt_src)
    );

    always #10 clk = ~clk;

    function automatic void model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_en[c] = 0; m_sel[c] = 0; m_hit[c] = 0; m_tot[c] = 0;
            m_hovf[c] = 0; m_tovf[c] = 0;
        end
    endfunction

    function automatic void model_step(bit we, bit [2:0] a, bit [31:0] wd,
                                       bit v, bit h, bit [1:0] s);
        for (int c = 0; c < NCH; c++) begin
            bit wr = we && (a == 3'(c * 4));
            if (wr && wd[3]) begin
                m_hit[c] = 0; m_tot[c] = 0; m_hovf[c] = 0; m_tovf[c] = 0;
            end else if (m_en[c] && v && m_sel[c] != 2'd3 && s == m_sel[c]) begin
                if (m_tot[c] == MAXV) m_tovf[c] = 1; else m_tot[c]++;
                if (h) begin
                    if (m_hit[c] == MAXV) m_hovf[c] = 1; else m_hit[c]++;
                end
            end
            if (wr) begin
                m_en[c]  = wd[0];
                m_sel[c] = wd[2:1];
            end
        end
    endfunction

    function automatic bit [31:0] model_read(bit [2:0] a);
        int c = a[2];
        case (a[1:0])
            2'd0: return {29'd0, m_sel[c], m_en[c]};
            2'd1: return 32'(m_hit[c]);
            2'd2: return 32'(m_tot[c]);
            default: return {30'd0, m_tovf[c], m_hovf[c]};
        endcase
    endfunction

    task automatic cycle(bit we, bit [2:0] a, bit [31:0] wd, bit v, bit h, bit [1:0] s);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        evt_valid = v; evt_hit = h; evt_src = s;
        model_step(we, a, wd, v, h, s);
        @(posedge clk);
    endtask

    task automatic check_reg(bit [2:0] a, string req);
        bit [31:0] exp;
        @(negedge clk);
        reg_we = 0; evt_valid = 0; reg_addr = a;
        #1;
        exp = model_read(a);
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%0h expected=%0h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int a = 0; a < 8; a++) check_reg(3'(a), req);
    endtask

    function automatic bit [31:0] ctl(bit en, bit [1:0] s, bit clr);
        return {28'd0, clr, s, en};
    endfunction

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check_all("R1");

        // R2 R7: ch0 watches CPU, ch1 watches DMA
        cycle(1, 3'd0, ctl(1, 2'd0, 0), 0, 0, 0);
        cycle(1, 3'd4, ctl(1, 2'd2, 0), 0, 0, 0);
        check_reg(3'd0, "R2");
        check_reg(3'd4, "R2");

        // R3: mixed single and burst events
        cycle(0, 0, 0, 1, 1, 2'd0);
        cycle(0, 0, 0, 1, 0, 2'd0);
        cycle(0, 0, 0, 1, 1, 2'd2);
        cycle(0, 0, 0, 1, 1, 2'd1);   // R6: PCI not selected anywhere
        for (int i = 0; i < 4; i++) cycle(0, 0, 0, 1, i[0], 2'd2);
        check_all("R3");

        // R8: event in the cycle of the control write uses old settings
        cycle(1, 3'd0, ctl(1, 2'd1, 0), 1, 1, 2'd1);
        cycle(0, 0, 0, 1, 1, 2'd1);
        check_reg(3'd1, "R8");
        check_reg(3'd2, "R8");

        // R6: disabled channel ignores events
        cycle(1, 3'd4, ctl(0, 2'd2, 0), 0, 0, 0);
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 1, 1, 2'd2);
        check_reg(3'd5, "R6");
        check_reg(3'd6, "R6");

        // R4: saturate channel 0 with hits
        for (int i = 0; i < MAXV + 5; i++) cycle(0, 0, 0, 1, 1, 2'd1);
        check_all("R4");

        // R5: clear with a colliding event, other channel untouched
        cycle(1, 3'd0, ctl(1, 2'd1, 1), 1, 1, 2'd1);
        check_all("R5");

        // R2: source code 3 matches nothing
        cycle(1, 3'd0, ctl(1, 2'd3, 0), 0, 0, 0);
        for (int i = 0; i < 4; i++) cycle(0, 0, 0, 1, 1, 2'(i));
        check_all("R2");

        // random phase
        for (int it = 0; it < 1500; it++) begin
            if ($urandom_range(0, 19) == 0) begin
                cycle(1, ($urandom_range(0, 1) != 0) ? 3'd4 : 3'd0,
                      ctl($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
                          $urandom_range(0, 3) == 0),
                      $urandom_range(0, 1), $urandom_range(0, 1), 2'($urandom_range(0, 3)));
            end else begin
                cycle(0, 3'($urandom_range(0, 7)), 32'hF, $urandom_range(0, 3) != 0,
                      $urandom_range(0, 1), 2'($urandom_range(0, 3)));
            end
            if (it % 50 == 49) check_all("R7");
        end

        // R1: reset mid-run returns everything to zero
        @(negedge clk); rst = 1; model_reset();
        @(posedge clk);
        @(negedge clk); rst = 0;
        check_all("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule